// File: doc/BRIEF.md
# Receive Queue with Hysteresis Handshake

This block sits between the receive shift register of a serial channel and the host. Every character arrives together with three error flags (parity, framing, break) and is stored as one entry in a 64-deep first-in first-out queue. The host pops entries through a read strobe, and the popped entry appears on a registered output one cycle later. A data-ready interrupt is raised while the fill level is at or above a programmable trigger level.

The same block also handles the modem handshake lines. When automatic output control is on, the selected active-low request pin goes high to pause the far-end sender once the fill level reaches trigger plus hysteresis. It drops low again once the level has drained to trigger minus hysteresis, and it keeps its state between those two points. When automatic input gating is on, the selected active-low monitored pin can suspend the local transmitter. That suspension only takes effect on a character boundary. A select bit decides which pair is automatic: request-to-send with clear-to-send, or terminal-ready with set-ready. The pin that is not selected follows its software request bit.

Top module: `rx_fifo_hsflow`

## Requirements
- R1: The queue holds 64 entries of 8 data bits plus 3 error bits and returns them in arrival order. A pop issued at one clock edge shows its entry on `rd_data`/`rd_err` after that edge. `fill_cnt` gives the current number of entries.
- R2: While `fifo_en` is 0, the queue is flushed to zero entries, writes and pops are ignored, `overrun` is cleared and `rx_irq` is 0.
- R3: `rx_irq` is 1 exactly when `fifo_en` is 1 and `fill_cnt` >= `trig_lvl`, with `trig_lvl` in 1..64.
- R4: With `auto_out_en` set and the selected request bit set, the selected request pin goes high once `fill_cnt` >= `trig_lvl` + `hyst`. For example, trigger 48 with hysteresis 8 pauses at 56.
- R5: The paused pin returns low once `fill_cnt` <= `trig_lvl` − `hyst`, where the lower threshold stops at 0. Between the two thresholds it keeps its previous state. For example, trigger 48 with hysteresis 8 resumes at 40.
- R6: `pair_sel` = 0 makes `rts_n` the automatic output and `cts_n` the monitored input. `pair_sel` = 1 makes `dtr_n` and `dsr_n` the automatic pair.
- R7: A request pin is low only while its request bit (`rts_req` for `rts_n`, `dtr_req` for `dtr_n`) is 1. Without automatic control it equals the inverse of that bit. After reset both pins are high.
- R8: With `auto_in_en` set and the monitored pin high, `tx_enable` goes to 0 at the first clock edge where `char_boundary` is 1. It returns to 1 at the next edge after the pin goes low or gating is turned off. After reset it is 1.
- R9: A write to a full queue with no pop in the same cycle is dropped, and it sets `overrun`. `overrun` stays set until the queue is disabled.
- R10: A pop from an empty queue leaves `rd_data`, `rd_err` and `fill_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Queue enable; 0 flushes |
| wr_en | input | 1 | Push strobe from the receive shift register |
| wr_data | input | 8 | Received character |
| wr_err | input | 3 | Error flags {break, framing, parity} |
| rd_en | input | 1 | Pop strobe from the host |
| rd_data | output | 8 | Last popped character |
| rd_err | output | 3 | Error flags of last popped character |
| fill_cnt | output | 7 | Number of stored entries |
| overrun | output | 1 | Sticky dropped-write flag |
| rx_irq | output | 1 | Data-ready interrupt |
| trig_lvl | input | 7 | Receive trigger level |
| hyst | input | 6 | Hysteresis half-width in characters |
| auto_out_en | input | 1 | Automatic request-pin control |
| auto_in_en | input | 1 | Automatic transmitter gating |
| pair_sel | input | 1 | 0: RTS/CTS pair, 1: DTR/DSR pair |
| rts_req | input | 1 | Software request for `rts_n` |
| dtr_req | input | 1 | Software request for `dtr_n` |
| cts_n | input | 1 | Monitored clear-to-send, active low |
| dsr_n | input | 1 | Monitored set-ready, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| char_boundary | input | 1 | Transmitter is between characters |
| tx_enable | output | 1 | Transmitter may start a character |

## Verification
The assertions assume that `trig_lvl` is in the range 1 to 64 and that the threshold and selection controls do not change in the same cycle as the checks that depend on them. The stimulus sets all controls while the queue is idle and only changes them between phases. The assertions also assume that the clock is running for the whole time that `rst_n` is high. The stimulus drives every input on the falling edge, so each push, pop and boundary pulse is sampled cleanly by exactly one rising edge.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   typedef enum logic {
      PAIR_RTS_CTS = 1'b0,
      PAIR_DTR_DSR = 1'b1
   } pair_e;

   localparam int unsigned PIN_COUNT = 2;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned WORD_W = 11,
   localparam int unsigned AW = $clog2(DEPTH),
   localparam int unsigned CW = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [WORD_W-1:0] push_word,
   input  logic              pop,
   output logic [WORD_W-1:0] pop_word,
   output logic [CW-1:0]     level,
   output logic              dropped
);
   logic [WORD_W-1:0] slots [DEPTH];
   logic [AW-1:0]     head_q, tail_q;
   logic [CW-1:0]     level_q;
   logic [WORD_W-1:0] out_q;
   logic              drop_q;
   logic              is_full, is_empty, pop_ok, push_ok;

   assign is_full  = (level_q == CW'(DEPTH));
   assign is_empty = (level_q == '0);
   assign pop_ok   = pop & ~flush & ~is_empty;
   assign push_ok  = push & ~flush & (~is_full | pop_ok);

   always_ff @(posedge clk) begin
      if (push_ok) slots[tail_q] <= push_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         level_q <= '0;
         out_q   <= '0;
         drop_q  <= 1'b0;
      end else if (flush) begin
         head_q  <= '0;
         tail_q  <= '0;
         level_q <= '0;
         drop_q  <= 1'b0;
      end else begin
         if (push_ok) tail_q <= tail_q + 1'b1;
         if (pop_ok) begin
            head_q <= head_q + 1'b1;
            out_q  <= slots[head_q];
         end
         case ({push_ok, pop_ok})
            2'b10:   level_q <= level_q + 1'b1;
            2'b01:   level_q <= level_q - 1'b1;
            default: level_q <= level_q;
         endcase
         if (push & ~push_ok) drop_q <= 1'b1;
      end
   end

   assign pop_word = out_q;
   assign level    = level_q;
   assign dropped  = drop_q;
endmodule

// File: rtl/rxq_hyst.sv
module rxq_hyst #(
   parameter int unsigned CW = 7,
   parameter int unsigned HW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] level,
   input  logic [CW-1:0] trig,
   input  logic [HW-1:0] hyst,
   output logic          paused
);
   localparam int unsigned XW = (CW > HW ? CW : HW) + 1;

   logic [XW-1:0] lvl_x, hi_x, lo_x, trig_x, hyst_x;
   logic          paused_q, paused_now;

   assign lvl_x  = XW'(level);
   assign trig_x = XW'(trig);
   assign hyst_x = XW'(hyst);
   assign hi_x   = trig_x + hyst_x;
   assign lo_x   = (trig_x > hyst_x) ? (trig_x - hyst_x) : '0;

   always_comb begin
      if (lvl_x >= hi_x)      paused_now = 1'b1;
      else if (lvl_x <= lo_x) paused_now = 1'b0;
      else                    paused_now = paused_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) paused_q <= 1'b0;
      else        paused_q <= paused_now;
   end

   assign paused = paused_now;
endmodule

// File: rtl/rxq_txgate.sv
module rxq_txgate (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_en,
   input  logic mon_n,
   input  logic char_boundary,
   output logic tx_enable
);
   logic allow, en_q;

   assign allow = ~(gate_en & mon_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             en_q <= 1'b1;
      else if (allow)         en_q <= 1'b1;
      else if (char_boundary) en_q <= 1'b0;
   end

   assign tx_enable = en_q;
endmodule

// File: rtl/rx_fifo_hsflow.sv
module rx_fifo_hsflow #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ERR_W = 3,
   parameter int unsigned HYST_W = 6,
   localparam int unsigned CW = $clog2(DEPTH) + 1,
   localparam int unsigned WORD_W = DATA_W + ERR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ERR_W-1:0]  wr_err,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [ERR_W-1:0]  rd_err,
   output logic [CW-1:0]     fill_cnt,
   output logic              overrun,
   output logic              rx_irq,
   input  logic [CW-1:0]     trig_lvl,
   input  logic [HYST_W-1:0] hyst,
   input  logic              auto_out_en,
   input  logic              auto_in_en,
   input  logic              pair_sel,
   input  logic              rts_req,
   input  logic              dtr_req,
   input  logic              cts_n,
   input  logic              dsr_n,
   output logic              rts_n,
   output logic              dtr_n,
   input  logic              char_boundary,
   output logic              tx_enable
);
   import rxq_pkg::*;

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (HYST_W >= CW + 1) begin : g_bad_hyst
      $error("HYST_W too wide for the count");
   end
   if (DATA_W == 0 || ERR_W == 0) begin : g_bad_word
      $error("DATA_W and ERR_W must be non-zero");
   end

   logic [WORD_W-1:0] pop_word;
   logic [CW-1:0]     level;
   logic              paused;
   logic              mon_n;
   logic [PIN_COUNT-1:0] req_vec, pin_vec;

   rxq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) i_store (
      .clk(clk), .rst_n(rst_n), .flush(~fifo_en),
      .push(wr_en), .push_word({wr_err, wr_data}),
      .pop(rd_en), .pop_word(pop_word),
      .level(level), .dropped(overrun)
   );

   rxq_hyst #(.CW(CW), .HW(HYST_W)) i_hyst (
      .clk(clk), .rst_n(rst_n), .level(level),
      .trig(trig_lvl), .hyst(hyst), .paused(paused)
   );

   assign mon_n = (pair_e'(pair_sel) == PAIR_DTR_DSR) ? dsr_n : cts_n;

   rxq_txgate i_txgate (
      .clk(clk), .rst_n(rst_n), .gate_en(auto_in_en), .mon_n(mon_n),
      .char_boundary(char_boundary), .tx_enable(tx_enable)
   );

   assign req_vec = {dtr_req, rts_req};

   for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pin
      logic auto_here;
      assign auto_here  = auto_out_en & (pair_sel == g[0]);
      assign pin_vec[g] = ~(req_vec[g] & ~(auto_here & paused));
   end

   assign rts_n    = pin_vec[0];
   assign dtr_n    = pin_vec[1];
   assign rd_data  = pop_word[DATA_W-1:0];
   assign rd_err   = pop_word[WORD_W-1:DATA_W];
   assign fill_cnt = level;
   assign rx_irq   = fifo_en & (level >= trig_lvl);
endmodule

// File: rtl/rx_fifo_hsflow_chk.sv
module rx_fifo_hsflow_chk #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ERR_W = 3,
   parameter int unsigned HYST_W = 6,
   localparam int unsigned CW = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fifo_en,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] rd_data,
   input logic [ERR_W-1:0]  rd_err,
   input logic [CW-1:0]     fill_cnt,
   input logic              overrun,
   input logic              rx_irq,
   input logic [CW-1:0]     trig_lvl,
   input logic [HYST_W-1:0] hyst,
   input logic              auto_out_en,
   input logic              pair_sel,
   input logic              rts_req,
   input logic              rts_n,
   input logic              char_boundary,
   input logic              tx_enable
);
   logic [CW+1:0] hi_c, lo_c, lvl_c;
   assign lvl_c = (CW+2)'(fill_cnt);
   assign hi_c  = (CW+2)'(trig_lvl) + (CW+2)'(hyst);
   assign lo_c  = ((CW+2)'(trig_lvl) > (CW+2)'(hyst)) ?
                  (CW+2)'(trig_lvl) - (CW+2)'(hyst) : '0;

   // R1
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_cnt <= CW'(DEPTH));
   // R2
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |=> (fill_cnt == '0) && !rx_irq);
   // R4
   pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_out_en && !pair_sel && lvl_c >= hi_c) |-> rts_n);
   // R5
   resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_out_en && !pair_sel && rts_req && lvl_c <= lo_c) |-> !rts_n);
   // R8
   tx_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_enable) |-> $past(char_boundary));
   // R9
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && wr_en && !rd_en && fill_cnt == CW'(DEPTH)) |=>
      (fill_cnt == CW'(DEPTH)) && overrun);
   // R9
   sticky_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && overrun) |=> overrun);
   // R10
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && rd_en && fill_cnt == '0) |=> $stable(rd_data) && $stable(rd_err));
endmodule

bind rx_fifo_hsflow rx_fifo_hsflow_chk #(
   .DEPTH(DEPTH), .DATA_W(DATA_W), .ERR_W(ERR_W), .HYST_W(HYST_W)
) i_chk (.*);

// File: tb/test_rx_fifo_hsflow.sv
module test_rx_fifo_hsflow;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [2:0] wr_err = '0;
   logic [7:0] rd_data;
   logic [2:0] rd_err;
   logic [6:0] fill_cnt;
   logic       overrun, rx_irq;
   logic [6:0] trig_lvl = 7'd48;
   logic [5:0] hyst = 6'd8;
   logic       auto_out_en = 1'b0, auto_in_en = 1'b0, pair_sel = 1'b0;
   logic       rts_req = 1'b0, dtr_req = 1'b0, cts_n = 1'b0, dsr_n = 1'b0;
   logic       rts_n, dtr_n, char_boundary = 1'b0, tx_enable;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rx_fifo_hsflow i_rx_fifo_hsflow (.*);

   typedef struct packed {
      logic       pop;
      logic [6:0] n;
      logic [6:0] cnt;
      logic       irq;
      logic       pin;
      logic       ovr;
   } vec_t;

   // trigger 48, hysteresis 8, automatic RTS
   localparam vec_t VECS [11] = '{
      '{1'b0, 7'd39, 7'd39, 1'b0, 1'b0, 1'b0},
      '{1'b0, 7'd9,  7'd48, 1'b1, 1'b0, 1'b0},
      '{1'b0, 7'd7,  7'd55, 1'b1, 1'b0, 1'b0},
      '{1'b0, 7'd1,  7'd56, 1'b1, 1'b1, 1'b0},
      '{1'b1, 7'd10, 7'd46, 1'b0, 1'b1, 1'b0},
      '{1'b1, 7'd5,  7'd41, 1'b0, 1'b1, 1'b0},
      '{1'b1, 7'd1,  7'd40, 1'b0, 1'b0, 1'b0},
      '{1'b0, 7'd10, 7'd50, 1'b1, 1'b0, 1'b0},
      '{1'b0, 7'd14, 7'd64, 1'b1, 1'b1, 1'b0},
      '{1'b0, 7'd2,  7'd64, 1'b1, 1'b1, 1'b1},
      '{1'b1, 7'd1,  7'd63, 1'b1, 1'b1, 1'b1}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic push_n(input int n, input logic [7:0] d, input logic [2:0] e);
      for (int i = 0; i < n; i++) begin
         wr_en = 1'b1; wr_data = d + 8'(i); wr_err = e;
         @(negedge clk);
      end
      wr_en = 1'b0;
   endtask

   task automatic pop_n(input int n);
      for (int i = 0; i < n; i++) begin
         rd_en = 1'b1;
         @(negedge clk);
      end
      rd_en = 1'b0;
   endtask

   task automatic flush_q();
      fifo_en = 1'b0;
      @(negedge clk);
      fifo_en = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R1 watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7 / R8 reset state
      chk("R7", "rts_n reset", rts_n, 1);
      chk("R7", "dtr_n reset", dtr_n, 1);
      chk("R8", "tx reset", tx_enable, 1);
      chk("R2", "cnt reset", fill_cnt, 0);
      chk("R2", "irq disabled", rx_irq, 0);

      // R4 R5 R3 R9 vector walk
      fifo_en = 1'b1; auto_out_en = 1'b1; rts_req = 1'b1;
      @(negedge clk);
      chk("R5", "rts_n empty", rts_n, 0);
      foreach (VECS[k]) begin
         if (VECS[k].pop) pop_n(int'(VECS[k].n));
         else             push_n(int'(VECS[k].n), 8'h00, 3'b000);
         chk("R3", $sformatf("cnt v%0d", k), fill_cnt, VECS[k].cnt);
         chk("R3", $sformatf("irq v%0d", k), rx_irq, VECS[k].irq);
         chk("R4", $sformatf("rts_n v%0d", k), rts_n, VECS[k].pin);
         chk("R9", $sformatf("ovr v%0d", k), overrun, VECS[k].ovr);
      end

      // R2 disable flushes and ignores writes
      fifo_en = 1'b0;
      @(negedge clk);
      chk("R2", "cnt after off", fill_cnt, 0);
      chk("R2", "ovr after off", overrun, 0);
      chk("R2", "irq off", rx_irq, 0);
      push_n(3, 8'h10, 3'b000);
      chk("R2", "write ignored", fill_cnt, 0);
      fifo_en = 1'b1;

      // R1 ordering with error flags
      wr_en = 1'b1; wr_data = 8'hA5; wr_err = 3'b101; @(negedge clk);
      wr_data = 8'h3C; wr_err = 3'b010; @(negedge clk);
      wr_data = 8'hFF; wr_err = 3'b000; @(negedge clk);
      wr_en = 1'b0;
      chk("R1", "cnt three", fill_cnt, 3);
      pop_n(1);
      chk("R1", "data first", {rd_err, rd_data}, {3'b101, 8'hA5});
      pop_n(1);
      chk("R1", "data second", {rd_err, rd_data}, {3'b010, 8'h3C});
      pop_n(1);
      chk("R1", "data third", {rd_err, rd_data}, {3'b000, 8'hFF});
      // R10 empty pop
      pop_n(2);
      chk("R10", "empty hold", {rd_err, rd_data}, {3'b000, 8'hFF});
      chk("R10", "empty cnt", fill_cnt, 0);

      // R6 DTR pair
      pair_sel = 1'b1; dtr_req = 1'b1;
      @(negedge clk);
      chk("R6", "dtr_n low", dtr_n, 0);
      push_n(56, 8'h00, 3'b000);
      chk("R6", "dtr_n paused", dtr_n, 1);
      chk("R6", "rts_n manual", rts_n, 0);
      flush_q();
      @(negedge clk);
      chk("R5", "dtr_n resumed", dtr_n, 0);

      // R7 manual and request gating
      auto_out_en = 1'b0; pair_sel = 1'b0;
      push_n(64, 8'h00, 3'b000);
      chk("R7", "manual rts_n full", rts_n, 0);
      auto_out_en = 1'b1; rts_req = 1'b0;
      flush_q();
      @(negedge clk);
      chk("R7", "rts_req off", rts_n, 1);

      // R8 transmitter gating
      auto_in_en = 1'b1; cts_n = 1'b1;
      @(negedge clk);
      chk("R8", "no boundary", tx_enable, 1);
      char_boundary = 1'b1; @(negedge clk); char_boundary = 1'b0;
      chk("R8", "suspended", tx_enable, 0);
      cts_n = 1'b0; @(negedge clk);
      chk("R8", "resumed", tx_enable, 1);
      pair_sel = 1'b1; cts_n = 1'b1; dsr_n = 1'b0;
      char_boundary = 1'b1; @(negedge clk); char_boundary = 1'b0;
      chk("R6", "dsr monitored", tx_enable, 1);
      auto_in_en = 1'b0; pair_sel = 1'b0;
      char_boundary = 1'b1; @(negedge clk); char_boundary = 1'b0;
      chk("R8", "gating off", tx_enable, 1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule